// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two 16-bit timer/counters. Each one is kept as a low byte and a high byte that software can read and write. A shared configuration register selects, for each channel, gating, the count source and one of four counting modes. A shared control register holds each channel's run bit and overflow flag. The clock is divided into machine cycles of `CYC_LEN` clocks. In timer mode a channel advances once per machine cycle. In counter mode it advances once for each falling edge seen on its event pin. That pin is sampled once per machine cycle.

The overflow flags form the interrupt requests. The interrupt controller acknowledges a request through a per-channel acknowledge pulse, and that pulse clears the flag. Channel 0 can be split into two independent 8-bit counters. In that split mode its high byte borrows channel 1's run bit and overflow flag, and channel 1 may then be parked.

Top module: `dual_tmr_unit`

## Requirements
- R1: After reset the configuration register, the control register and all four count bytes read 0, and `ovf_flag` is 0.
- R2: A machine cycle is `CYC_LEN` clocks and begins at reset release. A running channel in timer mode advances by exactly one at the last clock of each machine cycle, and by nothing at any other clock.
- R3: A channel counts only while its run bit is 1 and either its gate bit is 0 or its `gate_pin` bit is 1.
- R4: Mode 0 (code 00) is a 13-bit counter. Its low part is low-byte bits 4..0 and its high part is the whole high byte. Counting leaves low-byte bits 7..5 unchanged. Stepping past 0x1FFF wraps the counter to 0 and sets the overflow flag.
- R5: Mode 1 (code 01) is a 16-bit counter over {high, low}. Stepping past 0xFFFF wraps it to 0 and sets the overflow flag.
- R6: Mode 2 (code 10) counts only in the low byte. A step from 0xFF loads the low byte from the high byte and sets the overflow flag. The high byte never changes.
- R7: Mode 3 (code 11) on channel 0 makes its low byte an 8-bit counter under channel 0's own controls. Its high byte becomes an 8-bit machine-cycle counter run by channel 1's run bit, and a wrap of that high byte sets channel 1's flag. Channel 1 set to mode 3 holds both of its bytes.
- R8: In counter mode the event pin is sampled at clock `SAMPLE_PH` of each machine cycle. A high sample followed by a low sample adds one at the end of the machine cycle that took the low sample. A pulse that misses the sampling clock is not counted.
- R9: Register addresses are 0 for configuration, 1 for control, 2/3 for channel 0 low/high and 4/5 for channel 1 low/high. In the configuration register, bits 7..4 belong to channel 1 and bits 3..0 to channel 0. Each nibble holds, from its top bit down: gate, counter select, mode bit 1, mode bit 0. The control register holds bit 7 flag 1, bit 6 run 1, bit 5 flag 0 and bit 4 run 0, and bits 3..0 read 0.
- R10: An `irq_ack` bit clears that channel's overflow flag. If an overflow happens in the same clock, the flag stays set.
- R11: A register write in the same clock as a count step takes the written value. Writing a run bit leaves the count bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data for `rd_addr`, combinational |
| ev_pin | input | 2 | Event inputs for counter mode, one per channel |
| gate_pin | input | 2 | Gate inputs, one per channel |
| irq_ack | input | 2 | Interrupt acknowledge pulses, one per channel |
| ovf_flag | output | 2 | Overflow flags (interrupt requests) |

## Verification
A count step is due at the clock edge that ends a machine cycle, and it can be read through `rd_data` right after that edge. A write is seen right after the edge it was presented on. A falling edge on an event pin shows up after the end of the machine cycle whose sample was low. The bench keeps its own count of clocks since reset release, which gives it the phase. It presents every write and acknowledge at a chosen phase and reads back one clock before and one clock after each due edge. This shows that every result lands on its cycle and not a cycle early or late.

// File: rtl/dtc_pkg.sv
// Shared constants and types for the dual timer/counter unit.
// Assumes the register layout is fixed at two channels of byte-wide registers.
package dtc_pkg;
    localparam int N_TMR    = 2;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int CFG_W    = 4;
    localparam int A_MODE   = 0;
    localparam int A_CTRL   = 1;
    localparam int LO_BASE  = 2;   // channel i low byte at LO_BASE+2i, high at +1
    localparam int CTL_BASE = 4;   // channel i run bit at CTL_BASE+2i, flag at +1

    typedef enum logic [1:0] {
        M_PRESCALE = 2'b00,
        M_WIDE     = 2'b01,
        M_RELOAD   = 2'b10,
        M_SPLIT    = 2'b11
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   ctr;
        tmode_e mode;
    } tcfg_t;
endpackage

// File: rtl/dtc_cycle_gen.sv
// Machine-cycle phase generator.
// Produces a tick on the last clock of each CYC_LEN-clock machine cycle and a
// sample strobe at clock SAMPLE_PH. Assumes SAMPLE_PH < CYC_LEN - 1.
module dtc_cycle_gen #(
    parameter int CYC_LEN   = 12,
    parameter int SAMPLE_PH = 9
) (
    input  logic clk,
    input  logic rst_n,
    output logic mc_tick,
    output logic smp_stb
);
    localparam int PW = $clog2(CYC_LEN);
    localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);
    localparam logic [PW-1:0] SMP  = PW'(SAMPLE_PH);

    logic [PW-1:0] phase_q;

    // Phase counter that wraps once per machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)               phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                      phase_q <= phase_q + PW'(1);
    end

    assign mc_tick = (phase_q == LAST);
    assign smp_stb = (phase_q == SMP);
endmodule

// File: rtl/dtc_edge_det.sv
// Two-sample falling-edge detector for one event pin.
// Samples the pin once per machine cycle. A high-then-low pair raises a
// pending step that the next machine-cycle tick consumes.
module dtc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_stb,
    input  logic mc_tick,
    input  logic pin,
    output logic pend
);
    logic last_q;

    // Keep the previous sample and flag a high-to-low pair until the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            if (mc_tick) pend <= 1'b0;
            if (smp_stb) begin
                last_q <= pin;
                if (last_q && !pin) pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtc_count_core.sv
// Count datapath of one channel: low and high byte with the four modes.
// inc_lo steps the channel and inc_hi steps the high byte only in split mode.
// A write to a byte overrides any step to that byte in the same clock.
module dtc_count_core
    import dtc_pkg::*;
#(
    parameter int W        = 8,
    parameter int PRE_BITS = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmode_e       mode,
    input  logic         inc_lo,
    input  logic         inc_hi,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_q,
    output logic         ovf_main,
    output logic         ovf_split
);
    logic [W-1:0] nxt_lo, nxt_hi;
    logic lo_full, hi_full, pre_full;

    assign lo_full  = &lo_q;
    assign hi_full  = &hi_q;
    assign pre_full = &lo_q[PRE_BITS-1:0];

    // Next-state values and overflow pulses for the selected mode.
    always_comb begin
        nxt_lo    = lo_q;
        nxt_hi    = hi_q;
        ovf_main  = 1'b0;
        ovf_split = 1'b0;
        case (mode)
            M_PRESCALE: if (inc_lo) begin
                nxt_lo[PRE_BITS-1:0] = lo_q[PRE_BITS-1:0] + PRE_BITS'(1);
                if (pre_full) begin
                    nxt_hi   = hi_q + W'(1);
                    ovf_main = hi_full;
                end
            end
            M_WIDE: if (inc_lo) begin
                nxt_lo = lo_q + W'(1);
                if (lo_full) begin
                    nxt_hi   = hi_q + W'(1);
                    ovf_main = hi_full;
                end
            end
            M_RELOAD: if (inc_lo) begin
                if (lo_full) begin
                    nxt_lo   = hi_q;
                    ovf_main = 1'b1;
                end else begin
                    nxt_lo = lo_q + W'(1);
                end
            end
            default: begin
                if (inc_lo) begin
                    nxt_lo   = lo_q + W'(1);
                    ovf_main = lo_full;
                end
                if (inc_hi) begin
                    nxt_hi    = hi_q + W'(1);
                    ovf_split = hi_full;
                end
            end
        endcase
    end

    // Byte registers: a software write wins over a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= wr_lo ? wdata : nxt_lo;
            hi_q <= wr_hi ? wdata : nxt_hi;
        end
    end
endmodule

// File: rtl/dual_tmr_unit.sv
// Dual timer/counter unit: register file, run/gate logic and two count cores.
// Assumes gate_pin and ev_pin are already synchronous to clk. Flags are set
// by overflow, cleared by irq_ack, and fully rewritten by a control write.
module dual_tmr_unit
    import dtc_pkg::*;
#(
    parameter int CYC_LEN   = 12,
    parameter int SAMPLE_PH = 9,
    parameter int PRE_BITS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [N_TMR-1:0]  ev_pin,
    input  logic [N_TMR-1:0]  gate_pin,
    input  logic [N_TMR-1:0]  irq_ack,
    output logic [N_TMR-1:0]  ovf_flag
);
    logic                          mc_tick, smp_stb;
    logic [BYTE_W-1:0]             tmod_q;
    logic [N_TMR-1:0]              tr_q, tf_q, tf_set;
    logic [N_TMR-1:0]              ev_pend, run, halt, inc_lo, inc_hi;
    logic [N_TMR-1:0]              wr_lo, wr_hi, ovf_main, ovf_split;
    logic [N_TMR-1:0][BYTE_W-1:0]  lo_q, hi_q;
    tcfg_t                         cfg [N_TMR];
    logic                          wr_mode, wr_ctrl;

    assign wr_mode = wr_en && (wr_addr == ADDR_W'(A_MODE));
    assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));

    dtc_cycle_gen #(.CYC_LEN(CYC_LEN), .SAMPLE_PH(SAMPLE_PH)) u_cyc (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .smp_stb(smp_stb)
    );

    // Channel 1 parks in split mode; channel 0's high byte runs on channel 1's run bit.
    assign halt[0]   = 1'b0;
    assign halt[1]   = (cfg[1].mode == M_SPLIT);
    assign inc_hi[0] = mc_tick & tr_q[1];
    assign inc_hi[1] = 1'b0;

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        assign cfg[i]   = tcfg_t'(tmod_q[CFG_W*i +: CFG_W]);
        assign run[i]   = tr_q[i] & (~cfg[i].gate | gate_pin[i]);
        assign inc_lo[i] = mc_tick & run[i] & ~halt[i] & (cfg[i].ctr ? ev_pend[i] : 1'b1);
        assign wr_lo[i] = wr_en && (wr_addr == ADDR_W'(LO_BASE + 2*i));
        assign wr_hi[i] = wr_en && (wr_addr == ADDR_W'(LO_BASE + 2*i + 1));

        dtc_edge_det u_edge (
            .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mc_tick(mc_tick),
            .pin(ev_pin[i]), .pend(ev_pend[i])
        );

        dtc_count_core #(.W(BYTE_W), .PRE_BITS(PRE_BITS)) u_core (
            .clk(clk), .rst_n(rst_n), .mode(cfg[i].mode),
            .inc_lo(inc_lo[i]), .inc_hi(inc_hi[i]),
            .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(wr_data),
            .lo_q(lo_q[i]), .hi_q(hi_q[i]),
            .ovf_main(ovf_main[i]), .ovf_split(ovf_split[i])
        );
    end

    // A split-mode high-byte wrap on one channel raises the other channel's flag.
    assign tf_set[0] = ovf_main[0] | ovf_split[1];
    assign tf_set[1] = ovf_main[1] | ovf_split[0];

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)       tmod_q <= '0;
        else if (wr_mode) tmod_q <= wr_data;
    end

    // Run bits and flags: write first, then overflow set over acknowledge clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_q <= '0;
            tf_q <= '0;
        end else if (wr_ctrl) begin
            for (int i = 0; i < N_TMR; i++) begin
                tr_q[i] <= wr_data[CTL_BASE + 2*i];
                tf_q[i] <= wr_data[CTL_BASE + 2*i + 1];
            end
        end else begin
            tf_q <= (tf_q & ~irq_ack) | tf_set;
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_MODE)) rd_data = tmod_q;
        if (rd_addr == ADDR_W'(A_CTRL)) begin
            for (int i = 0; i < N_TMR; i++) begin
                rd_data[CTL_BASE + 2*i]     = tr_q[i];
                rd_data[CTL_BASE + 2*i + 1] = tf_q[i];
            end
        end
        for (int i = 0; i < N_TMR; i++) begin
            if (rd_addr == ADDR_W'(LO_BASE + 2*i))     rd_data = lo_q[i];
            if (rd_addr == ADDR_W'(LO_BASE + 2*i + 1)) rd_data = hi_q[i];
        end
    end

    assign ovf_flag = tf_q;
endmodule

// File: rtl/dual_tmr_unit_chk.sv
// Property checker for dual_tmr_unit, attached by bind.
// Watches the tick, the register writes and the stored state.
module dual_tmr_unit_chk (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [2:0]      wr_addr,
    input logic [1:0]      irq_ack,
    input logic            mc_tick,
    input logic [1:0]      tf_q,
    input logic [1:0]      tr_q,
    input logic [7:0]      tmod_q,
    input logic [1:0][7:0] lo_q,
    input logic [1:0][7:0] hi_q
);
    logic wr_ctrl;
    assign wr_ctrl = wr_en && (wr_addr == 3'd1);

    // R2: count bytes move only at a machine-cycle tick or on a write.
    a_r2_still_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !wr_en) |=> ($stable(lo_q) && $stable(hi_q)));

    // R3: channel 0's low byte holds while its run bit is 0.
    a_r3_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!tr_q[0] && !wr_en) |=> $stable(lo_q[0]));

    // R5: a flag rises only after a tick or a write.
    a_r5_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tf_q[0]) |-> ($past(mc_tick) || $past(wr_en)));

    // R6: the reload source byte never changes without a write.
    a_r6_reload_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (tmod_q[1:0] == 2'b10 && !wr_en) |=> $stable(hi_q[0]));

    // R7: channel 1 in mode 3 holds both bytes.
    a_r7_parked_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (tmod_q[5:4] == 2'b11 && !wr_en) |=> ($stable(lo_q[1]) && $stable(hi_q[1])));

    // R10: an acknowledge with no overflow source clears the flag.
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack[0] && !mc_tick && !wr_ctrl) |=> !tf_q[0]);
endmodule

bind dual_tmr_unit dual_tmr_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .irq_ack(irq_ack), .mc_tick(mc_tick), .tf_q(tf_q), .tr_q(tr_q),
    .tmod_q(tmod_q), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/tb_dual_tmr_unit.sv
// Directed bench: one task per scenario, phase tracked from reset release.
module tb_dual_tmr_unit;
    localparam int CYC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] ev_pin = '0;
    logic [1:0] gate_pin = '0;
    logic [1:0] irq_ack = '0;
    logic [1:0] ovf_flag;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    dual_tmr_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_pin(ev_pin), .gate_pin(gate_pin), .irq_ack(irq_ack),
        .ovf_flag(ovf_flag)
    );

    always #2.5 clk = ~clk;

    // Clock edges since reset release; the value mod CYC is the phase of the next edge.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input int addr, input int exp);
        rd_addr = 3'(addr);
        #1;
        check(req, {24'd0, rd_data}, exp);
    endtask

    // Advance to the next falling edge whose following rising edge has phase p.
    task automatic to_phase(input int p);
        do @(negedge clk); while ((cyc % CYC) != p);
    endtask

    task automatic run_cycles(input int n);
        for (int k = 0; k < n; k++) to_phase(0);
    endtask

    task automatic wr(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = 8'(data);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 6; a++) rd_chk("R1 reset value", a, 0);
        check("R1 reset flags", {30'd0, ovf_flag}, 0);
    endtask

    task automatic t_wide;
        wr(0, 8'h01); wr(2, 8'hFE); wr(3, 8'hFF);
        to_phase(0);
        wr(1, 8'h10);
        rd_chk("R11 run bit keeps count", 2, 8'hFE);
        to_phase(11);
        rd_chk("R2 no step before cycle end", 2, 8'hFE);
        to_phase(0);
        rd_chk("R2 one step per cycle", 2, 8'hFF);
        to_phase(0);
        rd_chk("R5 wrap low", 2, 8'h00);
        rd_chk("R5 wrap high", 3, 8'h00);
        check("R5 flag set", {30'd0, ovf_flag}, 1);
        rd_chk("R9 control layout", 1, 8'h30);
        wr(1, 8'h00);
    endtask

    task automatic t_prescale;
        wr(0, 8'h00); wr(2, 8'hFE); wr(3, 8'hFF);
        to_phase(0);
        wr(1, 8'h10);
        run_cycles(1);
        rd_chk("R4 low part step", 2, 8'hFF);
        run_cycles(1);
        rd_chk("R4 upper bits kept", 2, 8'hE0);
        rd_chk("R4 high wrap", 3, 8'h00);
        check("R4 flag set", {30'd0, ovf_flag}, 1);
        wr(1, 8'h00);
        wr(2, 8'h3F); wr(3, 8'h05);
        to_phase(0);
        wr(1, 8'h10);
        run_cycles(1);
        rd_chk("R4 carry low", 2, 8'h20);
        rd_chk("R4 carry high", 3, 8'h06);
        check("R4 no flag", {30'd0, ovf_flag}, 0);
        wr(1, 8'h00);
    endtask

    task automatic t_reload;
        wr(0, 8'h02); wr(3, 8'hF0); wr(2, 8'hFE);
        to_phase(0);
        wr(1, 8'h10);
        run_cycles(1);
        rd_chk("R6 step", 2, 8'hFF);
        run_cycles(1);
        rd_chk("R6 reloaded", 2, 8'hF0);
        rd_chk("R6 source kept", 3, 8'hF0);
        check("R6 flag set", {30'd0, ovf_flag}, 1);
        run_cycles(1);
        rd_chk("R6 after reload", 2, 8'hF1);
        wr(1, 8'h00);
    endtask

    task automatic t_gate;
        wr(0, 8'h09); wr(2, 8'h00); wr(3, 8'h00);
        gate_pin = 2'b00;
        to_phase(0);
        wr(1, 8'h10);
        run_cycles(3);
        rd_chk("R3 gate low blocks", 2, 8'h00);
        gate_pin = 2'b01;
        run_cycles(2);
        rd_chk("R3 gate high counts", 2, 8'h02);
        wr(1, 8'h00);
        run_cycles(2);
        rd_chk("R3 run off blocks", 2, 8'h02);
        gate_pin = 2'b00;
        wr(0, 8'h01);
        to_phase(0);
        wr(1, 8'h10);
        run_cycles(1);
        rd_chk("R3 gate unused counts", 2, 8'h03);
        wr(1, 8'h00);
    endtask

    task automatic t_counter;
        wr(0, 8'h50); wr(4, 8'h00); wr(5, 8'h00);
        to_phase(0);
        wr(1, 8'h40);
        ev_pin[1] = 1'b1;
        to_phase(0);
        ev_pin[1] = 1'b0;
        to_phase(11);
        rd_chk("R8 not before cycle end", 4, 8'h00);
        to_phase(0);
        rd_chk("R8 edge counted", 4, 8'h01);
        run_cycles(1);
        rd_chk("R8 steady low no count", 4, 8'h01);
        ev_pin[1] = 1'b1;
        to_phase(6);
        ev_pin[1] = 1'b0;
        run_cycles(2);
        rd_chk("R8 unsampled pulse ignored", 4, 8'h01);
        wr(1, 8'h00);
    endtask

    task automatic t_split;
        wr(1, 8'h00);
        wr(0, 8'h33); wr(2, 8'h10); wr(3, 8'hFF); wr(4, 8'h44); wr(5, 8'h55);
        to_phase(0);
        wr(1, 8'h50);
        run_cycles(1);
        rd_chk("R7 low byte own run", 2, 8'h11);
        rd_chk("R7 high byte wraps", 3, 8'h00);
        rd_chk("R7 borrowed flag", 1, 8'hD0);
        check("R7 flag pins", {30'd0, ovf_flag}, 2);
        rd_chk("R7 parked low", 4, 8'h44);
        rd_chk("R7 parked high", 5, 8'h55);
        run_cycles(1);
        rd_chk("R7 high byte steps", 3, 8'h01);
        wr(1, 8'h10);
        run_cycles(1);
        rd_chk("R7 low still runs", 2, 8'h13);
        rd_chk("R7 high stops with run1", 3, 8'h01);
        wr(1, 8'h00);
    endtask

    task automatic t_ack_prio;
        wr(0, 8'h01); wr(2, 8'hFF); wr(3, 8'hFF);
        to_phase(0);
        wr(1, 8'h10);
        to_phase(0);
        check("R10 flag before ack", {30'd0, ovf_flag}, 1);
        irq_ack = 2'b01;
        @(posedge clk); @(negedge clk);
        irq_ack = 2'b00;
        check("R10 ack clears", {30'd0, ovf_flag}, 0);
        wr(2, 8'hFF); wr(3, 8'hFF);
        to_phase(11);
        irq_ack = 2'b01;
        @(posedge clk); @(negedge clk);
        irq_ack = 2'b00;
        check("R10 overflow beats ack", {30'd0, ovf_flag}, 1);
        rd_chk("R10 wrapped", 2, 8'h00);
        to_phase(11);
        wr(2, 8'h80);
        rd_chk("R11 write beats step", 2, 8'h80);
        to_phase(0);
        rd_chk("R11 counts after write", 2, 8'h81);
        wr(1, 8'h00);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wide();
        t_prescale();
        t_reload();
        t_gate();
        t_counter();
        t_split();
        t_ack_prio();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule